// File: doc/BRIEF.md
# External Interrupt Sensitivity Detector

This block watches a set of external interrupt pins and turns their activity into one request line per group. Pins come in pairs. Each pair forms a group that shares one 2-bit sensitivity code, and each pin has its own enable bit. The enabled pins of a group are merged into a single group line: the line counts as asserted when any enabled pin is low, which is a NAND of the enabled pin levels. The block then looks for the chosen condition on the merged pin level. That condition is a rising edge, a falling edge, either edge, or a falling edge together with a live low level.

Edge events are caught in a pending latch per group. The latch holds until the interrupt controller pulses the group's acknowledge as it enters the service routine. In the low-level part of code 00 the request simply follows the line and is not stored. A wake output is built from the raw, unsynchronized pins. It can therefore pull a halted device out of HALT with no clock running.

Configuration goes through a plain write port into 8-bit control registers. Each register serves four pins, which make up two groups. The pins, the acknowledges, the requests and the wake output are all plain level signals with no handshake.

Top module: `ext_irq_sense`

## Requirements
- R1: Register `k` (selected by `cfg_idx`) resets to 00h. A write with `cfg_we` high takes effect at that clock edge. Bits 3:0 enable pins 4k..4k+3, one bit per pin with the lowest bit for the lowest pin. Bits 5:4 hold the code for group 2k (pins 4k, 4k+1). Bits 7:6 hold the code for group 2k+1 (pins 4k+2, 4k+3).
- R2: A group's merged pin level is the AND of its enabled pins. The group line is asserted (the NAND) whenever any enabled pin is low. A group with no enabled pin never requests, and no group affects another group's request.
- R3: The sensitivity codes are as follows. 01 latches a rising edge of the merged level. 10 latches a falling edge. 11 latches both edges. 00 latches a falling edge and also requests while the merged level is low.
- R4: In code 00 the low-level part is not stored. After the pending latch is cleared, the request stays high only while the merged level stays low, and it drops once the level returns high.
- R5: Pins pass through a two-flop synchronizer. A level request appears after the second rising clock edge following a pin change. A latched edge request appears after the third.
- R6: An acknowledge pulse on `irq_ack[g]` clears group g's pending latch at that clock edge.
- R7: A change of the merged level caused by a write to the enable bits is not taken as an edge. Edge detection is armed only once the enables have been stable for one clock.
- R8: `wake_o` is asserted whenever any of the following holds. It needs no clock edge to respond to a pin. (a) Any request is high. (b) In code 00, the raw merged level of a group is low. (c) The raw merged level differs from the last sampled level in a direction that the group's code triggers on.
- R9: A disabled pin has no effect on requests or on `wake_o`, whatever it does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 4*NREG | External interrupt pins, idle high |
| cfg_we | input | 1 | Control register write strobe |
| cfg_idx | input | max(1,clog2(NREG)) | Control register index |
| cfg_wdata | input | 8 | Control register write data |
| irq_ack | input | 2*NREG | Per-group acknowledge from the controller on service entry |
| irq_req | output | 2*NREG | Per-group interrupt request |
| wake_o | output | 1 | Asynchronous wake request for HALT exit |

## Verification
A wrong pending latch shows up at `irq_req` on the third clock after a pin change: a request appears that should not, or one is missing. A wrong sensitivity decode or a wrong field position shows up at the same point. A stale last-sampled level or a wrong arming flag shows in `wake_o` within a nanosecond of a pin change, before any clock edge. It also shows as a spurious request three clocks after an enable write. A latch that fails to clear is exposed on the first clock after the acknowledge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int CTRL_W         = 8;
  localparam int PINS_PER_REG   = 4;
  localparam int GROUPS_PER_REG = 2;
  localparam int PINS_PER_GROUP = 2;

  typedef enum logic [1:0] {
    SENS_FALL_LOW = 2'b00,
    SENS_RISE     = 2'b01,
    SENS_FALL     = 2'b10,
    SENS_BOTH     = 2'b11
  } sens_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NREG = 2,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NPIN = NREG * PINS_PER_REG,
  localparam int NGRP = NREG * GROUPS_PER_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [IDXW-1:0]   idx_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [NPIN-1:0]   en_o,
  output logic [2*NGRP-1:0] sens_o
);
  logic [CTRL_W-1:0] regs [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[r] <= '0;
      else if (we_i && (int'(idx_i) == r))
        regs[r] <= wdata_i;
    end
    assign en_o[PINS_PER_REG*r +: PINS_PER_REG] = regs[r][3:0];
    assign sens_o[4*r +: 4]                    = regs[r][7:4];

    // R1: a selected write lands in the register
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && (int'(idx_i) == r)) |=> (regs[r] == $past(wdata_i)));
  end
endmodule

// File: rtl/ext_irq_group.sv
module ext_irq_group
  import ext_irq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PINS_PER_GROUP-1:0] en_i,
  input  logic [1:0]                sens_i,
  input  logic [PINS_PER_GROUP-1:0] pin_sync_i,
  input  logic [PINS_PER_GROUP-1:0] pin_raw_i,
  input  logic                      ack_i,
  output logic                      req_o,
  output logic                      wake_o
);
  logic [PINS_PER_GROUP-1:0] en_prev;
  logic line_prev, pend;
  logic line, raw_line, armed;
  logic rise, fall, raw_rise, raw_fall;
  logic hit, raw_hit, level, raw_level;

  // merged pin level: AND of enabled pins, disabled pins read as high
  assign line     = &(pin_sync_i | ~en_i);
  assign raw_line = &(pin_raw_i  | ~en_i);
  assign armed    = (en_i == en_prev);

  assign rise     = armed &  line     & ~line_prev;
  assign fall     = armed & ~line     &  line_prev;
  assign raw_rise = armed &  raw_line & ~line_prev;
  assign raw_fall = armed & ~raw_line &  line_prev;

  always_comb begin
    unique case (sens_i)
      SENS_RISE: begin hit = rise;        raw_hit = raw_rise;            end
      SENS_FALL: begin hit = fall;        raw_hit = raw_fall;            end
      SENS_BOTH: begin hit = rise | fall; raw_hit = raw_rise | raw_fall; end
      default:   begin hit = fall;        raw_hit = raw_fall;            end
    endcase
  end

  assign level     = (sens_i == SENS_FALL_LOW) & ~line;
  assign raw_level = (sens_i == SENS_FALL_LOW) & ~raw_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev   <= '0;
      line_prev <= 1'b1;
      pend      <= 1'b0;
    end else begin
      en_prev   <= en_i;
      line_prev <= line;
      pend      <= (pend & ~ack_i) | hit;
    end
  end

  assign req_o  = pend | level;
  assign wake_o = req_o | raw_hit | raw_level;

  // R6: acknowledge without a fresh edge empties the latch
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !hit) |=> !pend);

  // R7: an enable change never produces a latched edge
  a_r7_no_edge_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i != en_prev) |=> !$rose(pend));

  // R2: a group with no enabled pin never starts a request
  a_r2_idle_group_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0 && en_prev == '0 && !pend) |=> !pend);

  // R3: rise-only code ignores a falling edge
  a_r3_rise_ignores_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sens_i == SENS_RISE && armed && !line && line_prev && !pend) |=> !pend);
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NREG = 2,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int NPIN = NREG * PINS_PER_REG,
  localparam int NGRP = NREG * GROUPS_PER_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              cfg_we,
  input  logic [IDXW-1:0]   cfg_idx,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic [NGRP-1:0]   irq_ack,
  output logic [NGRP-1:0]   irq_req,
  output logic              wake_o
);
  logic [NPIN-1:0]   en;
  logic [2*NGRP-1:0] sens;
  logic [NPIN-1:0]   pin_sync;
  logic [NGRP-1:0]   grp_wake;

  ext_irq_ctrl #(.NREG(NREG)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .idx_i(cfg_idx),
    .wdata_i(cfg_wdata), .en_o(en), .sens_o(sens)
  );

  ext_irq_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    ext_irq_group u_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en[PINS_PER_GROUP*g +: PINS_PER_GROUP]),
      .sens_i     (sens[2*g +: 2]),
      .pin_sync_i (pin_sync[PINS_PER_GROUP*g +: PINS_PER_GROUP]),
      .pin_raw_i  (pin_i[PINS_PER_GROUP*g +: PINS_PER_GROUP]),
      .ack_i      (irq_ack[g]),
      .req_o      (irq_req[g]),
      .wake_o     (grp_wake[g])
    );
  end

  assign wake_o = |grp_wake;

  // R8: any pending request is visible on the wake output
  a_r8_wake_covers_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> wake_o);
endmodule

// File: tb/sim_ext_irq_sense.sv
module sim_ext_irq_sense;
  localparam int NREG = 2;
  localparam int NP   = 4 * NREG;
  localparam int NG   = 2 * NREG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '1;
  logic          cfg_we = 1'b0;
  logic [0:0]    cfg_idx = '0;
  logic [7:0]    cfg_wdata = '0;
  logic [NG-1:0] ack = '0;
  logic [NG-1:0] req;
  logic          wake;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_irq_sense #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .irq_ack(ack),
    .irq_req(req), .wake_o(wake)
  );

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] data);
    cfg_idx   = idx[0:0];
    cfg_wdata = data;
    cfg_we    = 1'b1;
    step();
    cfg_we    = 1'b0;
  endtask

  function automatic logic [7:0] cfg(input int g, input int mode, input int enm);
    logic [7:0] v;
    v = '0;
    v[4 + 2*(g%2) +: 2] = mode[1:0];
    v[2*(g%2) +: 2]     = enm[1:0];
    return v;
  endfunction

  task automatic clear_all();
    pins = '1;
    for (int r = 0; r < NREG; r++) wr(r, 8'h00);
    ack = '1;
    step();
    ack = '0;
    step(3);
  endtask

  task automatic ack_grp(input int g);
    ack[g] = 1'b1;
    step();
    ack[g] = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    // R1: reset state, nothing enabled
    chk("R1 reset req", req, '0);
    chk("R1 reset wake", wake, 1'b0);
    pins = '0;
    #1 chk("R1 reset wake raw", wake, 1'b0);
    step(3);
    chk("R1 reset no enable req", req, '0);
    pins = '1;
    step(3);

    // Sweep: every group, every pin of the pair, every code
    for (int g = 0; g < NG; g++) begin
      for (int p = 0; p < 2; p++) begin
        for (int m = 0; m < 4; m++) begin
          bit fall_t, rise_t, lvl;
          fall_t = (m != 1);
          rise_t = (m == 1) || (m == 3);
          lvl    = (m == 0);
          clear_all();
          wr(g / 2, cfg(g, m, 1 << p));
          step(2);
          pins[2*g + p] = 1'b0;
          #1 chk($sformatf("R8 g%0d p%0d m%0d wake on fall", g, p, m), wake, fall_t);
          step();
          chk("R5 no req after one edge", req[g], 1'b0);
          step();
          chk($sformatf("R5 level after two edges m%0d", m), req[g], lvl);
          step();
          chk($sformatf("R1 R3 fall req g%0d m%0d", g, m), req[g], fall_t);
          chk("R2 other groups quiet", req & ~(NG'(1) << g), '0);
          ack_grp(g);
          chk($sformatf("R4 R6 after ack m%0d", m), req[g], lvl);
          chk("R8 wake after ack", wake, lvl);
          pins[2*g + p] = 1'b1;
          #1 chk($sformatf("R8 wake on rise m%0d", m), wake, rise_t || lvl);
          step(2);
          chk($sformatf("R4 level dropped m%0d", m), req[g], 1'b0);
          step();
          chk($sformatf("R3 rise req g%0d m%0d", g, m), req[g], rise_t);
          ack_grp(g);
          chk("R6 cleared after rise", req[g], 1'b0);
        end
      end
    end

    for (int g = 0; g < NG; g++) begin
      // R2: NAND merge of both pins, code 10
      clear_all();
      wr(g / 2, cfg(g, 2, 3));
      step(2);
      pins[2*g] = 1'b0;
      step(3);
      chk("R2 first pin low", req[g], 1'b1);
      ack_grp(g);
      pins[2*g+1] = 1'b0;
      step(3);
      chk("R2 second pin adds no edge", req[g], 1'b0);
      pins[2*g] = 1'b1;
      step(3);
      chk("R2 line held by other pin", req[g], 1'b0);
      wr(g / 2, cfg(g, 1, 3));
      step(2);
      pins[2*g+1] = 1'b1;
      step(3);
      chk("R2 rise only when both high", req[g], 1'b1);
      ack_grp(g);

      // R9: disabled partner pin ignored, code 11
      clear_all();
      wr(g / 2, cfg(g, 3, 1));
      step(2);
      pins[2*g+1] = 1'b0;
      #1 chk("R9 wake ignores disabled pin", wake, 1'b0);
      step(3);
      chk("R9 disabled pin low", req[g], 1'b0);
      pins[2*g+1] = 1'b1;
      step(3);
      chk("R9 disabled pin high", req[g], 1'b0);

      // R7: enabling a pin already low is no edge
      clear_all();
      pins[2*g] = 1'b0;
      step(3);
      wr(g / 2, cfg(g, 2, 1));
      step(4);
      chk("R7 no edge on enable", req[g], 1'b0);
      chk("R7 no wake on enable", wake, 1'b0);
      pins[2*g] = 1'b1;
      step(3);
      chk("R7 rise ignored in code 10", req[g], 1'b0);
      pins[2*g] = 1'b0;
      step(3);
      chk("R7 armed afterwards", req[g], 1'b1);
      ack_grp(g);
      pins = '1;
      step(3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule